// File: doc/BRIEF.md
# AES Round-Key Schedule Generator

This block turns a cipher key of 128, 192 or 256 bits into the complete set of AES round keys and keeps them for a cipher core to read. The key arrives on a single 256-bit bus. Shorter keys sit in the upper bits, and any bits below the selected length are not used. A 2-bit code selects the key length. A one-cycle start pulse begins the expansion. While the schedule is being built, an idle-high finish flag drops. Once the flag is high again, the cipher core fetches each 128-bit round key by its round number through a combinational read port.

The schedule is built one 32-bit word per clock. A key of Nk words (4, 6 or 8) is written into word storage in the cycle the start pulse is accepted. Every later cycle then derives one new word from the previous word and the word Nk positions back, until 4*(Nr+1) words exist, with Nr equal to 10, 12 or 14. The key bus, the length code and the read index are plain control-style pins: no data handshake is needed. The key bus and the length code are sampled only in the cycle a start pulse is accepted. The read port is valid whenever the finish flag is high.

Top module: `aes_key_sched`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released, done_o is 1 and every round key read from the port is all zeros.
- R2: A start pulse accepted while idle drives done_o low from the next cycle. done_o stays low for exactly 40, 46 or 52 cycles for length codes 00, 01 and 10, and then returns high.
- R3: Length code 00 selects a 4-word key with 10 rounds. Code 01 selects 6 words with 12 rounds. Code 10 selects 8 words with 14 rounds. After completion, round r reads back words 4r..4r+3 of the standard AES key schedule, word 4r in bits 127:96. For the 128-bit key 2b7e151628aed2a6abf7158809cf4f3c, round 10 reads d014f9a8c9ee2589e13f0cc8b6630ca6.
- R4: The key is MSB-aligned. Key word j is taken from bits 255-32j down to 224-32j. Bits below the selected length do not affect the schedule.
- R5: When i mod Nk is 0, a new word applies the rotate, byte substitution and round-constant step. For an 8-word key, when i mod 8 is 4, the word applies byte substitution only.
- R6: Length code 11 behaves exactly like code 10.
- R7: A start pulse that arrives while done_o is low is ignored. The running expansion keeps its timing and its key.
- R8: A start pulse with a nonzero reserved field (rsvd_i) is ignored. done_o stays high and the stored round keys are unchanged.
- R9: After an expansion, round indexes above that key length's Nr read all zeros, because storage beyond the key words is cleared on each accepted start. Index 15 always reads all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_i | input | 256 | Cipher key, MSB-aligned |
| klen_i | input | 2 | Key length code: 00 = 128, 01 = 192, 10 and 11 = 256 |
| rsvd_i | input | 4 | Reserved round field, must be zero for a start to be taken |
| start_i | input | 1 | One-cycle start pulse |
| done_o | output | 1 | High when idle, low while the schedule is being built |
| rd_round_i | input | 4 | Round index to read, 0 to 15 |
| rd_key_o | output | 128 | Round key for rd_round_i (combinational) |

## Verification
The schedule is tried with each of the three key lengths and with the alternate 256-bit code. The 128-bit case uses a published test key. Together these separate the length decoding, the per-length cycle count and the extra substitution step that only 8-word keys take. The same 128-bit key is then driven with random bits below its length, which shows whether the alignment and masking are right. Three further patterns are used:
- A start pulse during a running expansion, which exposes a start guard that is missing.
- A start pulse with a nonzero reserved field, which exposes a reserved-field guard that is missing.
- A long key followed by a short key, which shows whether stale round keys are cleared.

// File: rtl/aks_pkg.sv
package aks_pkg;
  localparam int WORD_W     = 32;
  localparam int MAX_NK     = 8;
  localparam int MAX_ROUNDS = 14;
  localparam int MAX_WORDS  = 4 * (MAX_ROUNDS + 1);
  localparam int IDX_W      = $clog2(MAX_WORDS);
  localparam int KEY_W      = WORD_W * MAX_NK;
  localparam int BLK_W      = 4 * WORD_W;
  localparam int RIDX_W     = 4;
  localparam int NK_W       = 4;
  localparam int POS_W      = 3;

  typedef enum logic [1:0] {
    KL_128    = 2'b00,
    KL_192    = 2'b01,
    KL_256    = 2'b10,
    KL_256ALT = 2'b11
  } klen_e;

  function automatic logic [NK_W-1:0] nk_of(input logic [1:0] code);
    case (klen_e'(code))
      KL_128:  return NK_W'(4);
      KL_192:  return NK_W'(6);
      default: return NK_W'(8);
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] last_of(input logic [1:0] code);
    case (klen_e'(code))
      KL_128:  return IDX_W'(43);
      KL_192:  return IDX_W'(51);
      default: return IDX_W'(MAX_WORDS - 1);
    endcase
  endfunction

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, t;
    acc = 8'h00;
    t   = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ t;
      t = xtime(t);
    end
    return acc;
  endfunction

  // Byte substitution: multiplicative inverse (x^254) followed by the affine map.
  function automatic logic [7:0] sub_byte(input logic [7:0] x);
    logic [7:0] r, base, y;
    r    = 8'h01;
    base = x;
    for (int k = 0; k < 8; k++) begin
      if (k != 0) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    y = r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
    return y;
  endfunction
endpackage

// File: rtl/aks_sbox.sv
module aks_sbox (
  input  logic [7:0] in_i,
  output logic [7:0] out_o
);
  assign out_o = aks_pkg::sub_byte(in_i);
endmodule

// File: rtl/aks_word_xform.sv
module aks_word_xform
  import aks_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0]     prev_i,
  input  logic [W-1:0]     back_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [NK_W-1:0]  nk_i,
  input  logic [7:0]       rcon_i,
  output logic [W-1:0]     next_o
);
  localparam int NBYTES = W / 8;

  logic          at_head;
  logic          at_mid;
  logic [W-1:0]  sub_in;
  logic [W-1:0]  sub_out;
  logic [W-1:0]  temp;

  assign at_head = (pos_i == '0);
  assign at_mid  = (nk_i == NK_W'(8)) && (pos_i == POS_W'(4));
  assign sub_in  = at_head ? {prev_i[W-9:0], prev_i[W-1:W-8]} : prev_i;

  for (genvar b = 0; b < NBYTES; b++) begin : g_sub
    aks_sbox u_sbox (
      .in_i  (sub_in[8*b +: 8]),
      .out_o (sub_out[8*b +: 8])
    );
  end

  always_comb begin
    if (at_head)      temp = sub_out ^ {rcon_i, {(W-8){1'b0}}};
    else if (at_mid)  temp = sub_out;
    else              temp = prev_i;
  end

  assign next_o = temp ^ back_i;
endmodule

// File: rtl/aks_ctrl.sv
module aks_ctrl
  import aks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       klen_i,
  input  logic [3:0]       rsvd_i,
  output logic             load_o,
  output logic [NK_W-1:0]  load_nk_o,
  output logic             we_o,
  output logic [IDX_W-1:0] widx_o,
  output logic [POS_W-1:0] pos_o,
  output logic [NK_W-1:0]  nk_o,
  output logic [7:0]       rcon_o,
  output logic             busy_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  logic [POS_W-1:0] pos_q;
  logic [NK_W-1:0]  nk_q;
  logic [7:0]       rcon_q;
  logic             accept;

  assign accept    = start_i && !busy_q && (rsvd_i == '0);
  assign load_o    = accept;
  assign load_nk_o = nk_of(klen_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      pos_q  <= '0;
      nk_q   <= NK_W'(4);
      rcon_q <= 8'h01;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= IDX_W'(nk_of(klen_i));
      last_q <= last_of(klen_i);
      pos_q  <= '0;
      nk_q   <= nk_of(klen_i);
      rcon_q <= 8'h01;
    end else if (busy_q) begin
      idx_q  <= idx_q + IDX_W'(1);
      pos_q  <= (pos_q == POS_W'(nk_q - NK_W'(1))) ? '0 : pos_q + POS_W'(1);
      if (pos_q == '0) rcon_q <= xtime(rcon_q);
      if (idx_q == last_q) busy_q <= 1'b0;
    end
  end

  assign we_o   = busy_q;
  assign widx_o = idx_q;
  assign pos_o  = pos_q;
  assign nk_o   = nk_q;
  assign rcon_o = rcon_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/aks_store.sv
module aks_store
  import aks_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [NK_W-1:0]   load_nk_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [NK_W-1:0]   nk_i,
  input  logic [RIDX_W-1:0] rd_round_i,
  output logic [WORD_W-1:0] prev_o,
  output logic [WORD_W-1:0] back_o,
  output logic [BLK_W-1:0]  round_key_o
);
  logic [WORD_W-1:0] words [MAX_WORDS];

  for (genvar j = 0; j < MAX_WORDS; j++) begin : g_word
    logic [WORD_W-1:0] load_val;
    if (j < MAX_NK) begin : g_keyw
      assign load_val = (NK_W'(j) < load_nk_i) ? key_i[KEY_W-1-WORD_W*j -: WORD_W] : '0;
    end else begin : g_zero
      assign load_val = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               words[j] <= '0;
      else if (load_i)                          words[j] <= load_val;
      else if (we_i && (widx_i == IDX_W'(j)))   words[j] <= wdata_i;
    end
  end

  logic [IDX_W-1:0] prev_idx;
  logic [IDX_W-1:0] back_idx;
  logic [IDX_W-1:0] base_idx;

  assign prev_idx = widx_i - IDX_W'(1);
  assign back_idx = widx_i - IDX_W'(nk_i);
  assign base_idx = {rd_round_i, 2'b00};

  always_comb begin
    prev_o = '0;
    back_o = '0;
    for (int j = 0; j < MAX_WORDS; j++) begin
      if (prev_idx == IDX_W'(j)) prev_o = words[j];
      if (back_idx == IDX_W'(j)) back_o = words[j];
    end
  end

  always_comb begin
    round_key_o = '0;
    for (int q = 0; q < 4; q++) begin
      for (int j = 0; j < MAX_WORDS; j++) begin
        if ((base_idx + IDX_W'(q)) == IDX_W'(j) && rd_round_i <= RIDX_W'(MAX_ROUNDS))
          round_key_o[BLK_W-1-WORD_W*q -: WORD_W] = words[j];
      end
    end
  end
endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched
  import aks_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [1:0]        klen_i,
  input  logic [3:0]        rsvd_i,
  input  logic              start_i,
  output logic              done_o,
  input  logic [RIDX_W-1:0] rd_round_i,
  output logic [BLK_W-1:0]  rd_key_o
);
  logic              load;
  logic [NK_W-1:0]   load_nk;
  logic              we;
  logic [IDX_W-1:0]  widx;
  logic [POS_W-1:0]  pos;
  logic [NK_W-1:0]   nk;
  logic [7:0]        rcon;
  logic              busy;
  logic [WORD_W-1:0] prev_w;
  logic [WORD_W-1:0] back_w;
  logic [WORD_W-1:0] next_w;

  aks_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .klen_i    (klen_i),
    .rsvd_i    (rsvd_i),
    .load_o    (load),
    .load_nk_o (load_nk),
    .we_o      (we),
    .widx_o    (widx),
    .pos_o     (pos),
    .nk_o      (nk),
    .rcon_o    (rcon),
    .busy_o    (busy)
  );

  aks_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .load_nk_i   (load_nk),
    .key_i       (key_i),
    .we_i        (we),
    .widx_i      (widx),
    .wdata_i     (next_w),
    .nk_i        (nk),
    .rd_round_i  (rd_round_i),
    .prev_o      (prev_w),
    .back_o      (back_w),
    .round_key_o (rd_key_o)
  );

  aks_word_xform u_xform (
    .prev_i (prev_w),
    .back_i (back_w),
    .pos_i  (pos),
    .nk_i   (nk),
    .rcon_i (rcon),
    .next_o (next_w)
  );

  assign done_o = !busy;
endmodule

// File: rtl/aks_checker.sv
module aks_checker (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   klen_i,
  input logic [3:0]   rsvd_i,
  input logic         start_i,
  input logic         done_o,
  input logic [3:0]   rd_round_i,
  input logic [127:0] rd_key_o
);
  logic [7:0] low_cnt;
  logic [7:0] exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      exp_len <= '0;
    end else begin
      low_cnt <= done_o ? 8'd0 : low_cnt + 8'd1;
      if (start_i && done_o && rsvd_i == 4'd0)
        exp_len <= (klen_i == 2'b00) ? 8'd40 : (klen_i == 2'b01) ? 8'd46 : 8'd52;
    end
  end

  // R1: idle right after reset release
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> done_o);

  // R2: accepted start drops the finish flag
  a_r2_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && done_o && rsvd_i == 4'd0) |=> !done_o);

  // R2 / R7: busy window length set only by the accepted start
  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (low_cnt == exp_len));

  // R8: nonzero reserved field blocks the start
  a_r8_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && done_o && rsvd_i != 4'd0) |=> done_o);

  // R9: index 15 reads zero
  a_r9_idx15_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_round_i == 4'd15) |-> (rd_key_o == '0));
endmodule

bind aes_key_sched aks_checker u_aks_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .klen_i     (klen_i),
  .rsvd_i     (rsvd_i),
  .start_i    (start_i),
  .done_o     (done_o),
  .rd_round_i (rd_round_i),
  .rd_key_o   (rd_key_o)
);

// File: tb/tb_aes_key_sched.sv
`timescale 1ns/1ps
module tb_aes_key_sched;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] key_r = '0;
  logic [1:0]   len_r = 2'b00;
  logic [3:0]   rsvd_r = 4'd0;
  logic         start_r = 1'b0;
  logic         done_o;
  logic [3:0]   ridx_r = 4'd0;
  logic [127:0] rd_key_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  aes_key_sched dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_i      (key_r),
    .klen_i     (len_r),
    .rsvd_i     (rsvd_r),
    .start_i    (start_r),
    .done_o     (done_o),
    .rd_round_i (ridx_r),
    .rd_key_o   (rd_key_o)
  );

  // ---------------- reference model ----------------
  byte unsigned sb [256];
  logic [31:0]  mw [60];
  int           rem = 0;

  function automatic byte unsigned rotl8(byte unsigned v, int s);
    return byte'((v << s) | (v >> (8 - s)));
  endfunction

  initial begin
    byte unsigned p, q, x;
    p = 1; q = 1;
    do begin
      p = byte'(p ^ (p << 1) ^ ((p & 8'h80) != 0 ? 8'h1b : 8'h00));
      q = byte'(q ^ (q << 1));
      q = byte'(q ^ (q << 2));
      q = byte'(q ^ (q << 4));
      if ((q & 8'h80) != 0) q = byte'(q ^ 8'h09);
      x = byte'(q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4));
      sb[p] = byte'(x ^ 8'h63);
    end while (p != 1);
    sb[0] = 8'h63;
  end

  function automatic logic [31:0] subw(logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic int nk_for(logic [1:0] c);
    return (c == 2'b00) ? 4 : (c == 2'b01) ? 6 : 8;
  endfunction

  task automatic build(logic [255:0] k, logic [1:0] c);
    int nk, total;
    logic [7:0] rc;
    logic [31:0] t;
    nk = nk_for(c);
    total = 4 * (nk + 7);
    rc = 8'h01;
    for (int i = 0; i < 60; i++) mw[i] = '0;
    for (int i = 0; i < nk; i++) mw[i] = k[255 - 32*i -: 32];
    for (int i = nk; i < total; i++) begin
      t = mw[i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
      end else if (nk == 8 && i % 8 == 4) begin
        t = subw(t);
      end
      mw[i] = t ^ mw[i-nk];
    end
  endtask

  function automatic logic [127:0] exp_rk(int r);
    if (r > 14) return '0;
    return {mw[4*r], mw[4*r+1], mw[4*r+2], mw[4*r+3]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rem = 0;
      for (int i = 0; i < 60; i++) mw[i] = '0;
    end else if (rem > 0) begin
      rem = rem - 1;
    end else if (start_r && rsvd_r == 4'd0) begin
      rem = 4 * (nk_for(len_r) + 7) - nk_for(len_r);
      build(key_r, len_r);
    end
  end

  // ---------------- checking ----------------
  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      check("R2", {127'h0, done_o}, {127'h0, rem == 0});
      if (rem == 0) check("R3", rd_key_o, exp_rk(int'(ridx_r)));
    end
  end

  task automatic pulse(logic [255:0] k, logic [1:0] c, logic [3:0] rs);
    @(negedge clk);
    key_r = k; len_r = c; rsvd_r = rs; start_r = 1'b1;
    @(negedge clk);
    start_r = 1'b0; rsvd_r = 4'd0;
  endtask

  task automatic expand_timed(logic [255:0] k, logic [1:0] c, int exp_low, string req);
    int n;
    pulse(k, c, 4'd0);
    n = 0;
    while (!done_o && n < 200) begin
      n++;
      @(negedge clk);
    end
    check(req, 128'(n), 128'(exp_low));
  endtask

  task automatic sweep();
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      ridx_r = 4'(r);
    end
    @(negedge clk);
  endtask

  task automatic read_at(int r, output logic [127:0] v);
    @(negedge clk);
    ridx_r = 4'(r);
    #1;
    v = rd_key_o;
  endtask

  localparam logic [255:0] K128 = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
  localparam logic [127:0] K128_R10 = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
  localparam logic [255:0] K192 = {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0};
  localparam logic [255:0] K256 = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;

  initial begin
    logic [127:0] v, saved;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {127'h0, done_o}, {127'h0, 1'b1});
    for (int r = 0; r < 16; r++) begin
      ridx_r = 4'(r);
      #1;
      check("R1", rd_key_o, '0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {127'h0, done_o}, {127'h0, 1'b1});

    // R2/R3: 128-bit published key
    expand_timed(K128, 2'b00, 40, "R2");
    read_at(10, v);
    check("R3", v, K128_R10);
    sweep();

    // R2/R3: 192-bit key
    expand_timed(K192, 2'b01, 46, "R2");
    sweep();

    // R2/R5: 256-bit key, extra substitution step
    expand_timed(K256, 2'b10, 52, "R2");
    read_at(3, v);
    check("R5", v, exp_rk(3));
    read_at(14, saved);
    check("R5", saved, exp_rk(14));
    sweep();

    // R6: code 11 matches code 10
    expand_timed(K256, 2'b11, 52, "R6");
    read_at(14, v);
    check("R6", v, saved);
    sweep();

    // R9: short key after a long one clears upper rounds
    expand_timed(K128 | {128'h0, 128'hdeadbeef_0badf00d_13572468_fedcba98}, 2'b00, 40, "R4");
    read_at(10, v);
    check("R4", v, K128_R10);
    for (int r = 11; r < 16; r++) begin
      read_at(r, v);
      check("R9", v, '0);
    end

    // R7: start while busy is ignored
    pulse(K128, 2'b00, 4'd0);
    repeat (5) @(negedge clk);
    pulse(K256, 2'b10, 4'd0);
    while (!done_o) @(negedge clk);
    read_at(10, v);
    check("R7", v, K128_R10);
    read_at(12, v);
    check("R7", v, '0);

    // R8: nonzero reserved field blocks the start
    pulse(K256, 2'b10, 4'd5);
    check("R8", {127'h0, done_o}, {127'h0, 1'b1});
    read_at(10, v);
    check("R8", v, K128_R10);
    sweep();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule